// File: doc/BRIEF.md
# Banked Memory Attribute Remap Register

This block holds a 32-bit attribute remap word in two banked copies, one for the Secure state and one for the Non-secure state, and uses the copy that matches a lookup request to turn a 3-bit region attribute index and a shareable flag into a memory type and a mapped shareability. A translation unit drives the lookup port and gets its answer in the same cycle. System software reaches the register through a simple read/write port. That port is gated by the privilege level, the selected translation format and a write lock for the Secure copy.

The index is formed as {TEX[0], C, B}, giving values 0 to 7. Each index has its own 2-bit type field. Each index also has one bit that picks inner or outer shareability when a Normal region is shareable. Two global bits decide whether Normal memory counts as shareable, one for each value of the incoming S bit. Two more bits, the device equivalents, are stored and read back but play no part in the lookup. A type code that has no defined meaning raises an error flag, and the outputs are forced to the safest device type.

Top module: `attr_remap_bank`

## Requirements
- R1: A synchronous reset clears both copies to zero and clears the read data and the fault output. After reset, every lookup returns type 00 with outer shareability and no error.
- R2: An access with privilege level 0 (`reg_el` = 0) is refused. The fault output is 1 in the cycle after the request, a write has no effect, and the read data is zero.
- R3: When `long_fmt` is 1, every access is refused in the same way as in R2.
- R4: An access granted with privilege level 1, 2 or 3 uses the copy chosen by `reg_secure` (1 = Secure) and never changes the other copy. The data of a granted read appears on `reg_rdata` in the cycle after the request.
- R5: While `sec_wr_lock` is 1, a write to the Secure copy is refused with a fault and leaves that copy unchanged. Secure reads and Non-secure writes still work.
- R6: Bits [23:20] always read as zero, whatever was written to them.
- R7: The lookup uses the copy chosen by `lk_secure`. For index n, the type comes from bits [2n+1:2n]. The codes are 00 = strongly ordered device, 01 = other device, 10 = Normal, and 11 = undefined. The output never shows 11.
- R8: For a Normal region, bit 19 (when `lk_share_in` = 1) or bit 18 (when `lk_share_in` = 0) decides shareability. When the chosen bit is 0, `lk_share` is 00 (non-shareable).
- R9: For a shareable Normal region, bit 24+n picks the result: 0 gives `lk_share` = 10 (outer) and 1 gives `lk_share` = 01 (inner).
- R10: For a device region (type 00 or 01), `lk_share` is 10 (outer). Bits 16, 17, 18, 19 and 24+n have no effect on the result.
- R11: A type field of 11 sets `lk_err`, and the outputs become type 00 with `lk_share` = 10.
- R12: The fault output is high only in the cycle after a refused request, so a single refused request gives a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_el | input | 2 | Privilege level of the access (0 = unprivileged) |
| reg_secure | input | 1 | Security state of the access (1 = Secure) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_fault | output | 1 | Access refused, one cycle after the request |
| long_fmt | input | 1 | Long translation format in use; blocks all register accesses |
| sec_wr_lock | input | 1 | Blocks writes to the Secure copy |
| lk_idx | input | 3 | Region attribute index {TEX[0], C, B} |
| lk_share_in | input | 1 | Shareable bit of the region descriptor |
| lk_secure | input | 1 | Security state of the lookup |
| lk_type | output | 2 | Mapped memory type |
| lk_share | output | 2 | Mapped shareability: 00 none, 01 inner, 10 outer |
| lk_err | output | 1 | Undefined type code found |

## Verification
The hardest situation to reach is a lookup that hits a mixed configuration. Such a configuration has Normal, device and undefined type fields side by side, together with different shareability bits in each of the two banked copies. Only then can a bench see a wrong copy being selected, or a device bit leaking into the output. The bench loads both copies with a set of hand-built and pseudo-random words through the access port. After each load it sweeps every combination of index, shareable bit and lookup security state, and compares the outputs with a value it computes from the stored word.

// File: rtl/attr_remap_pkg.sv
package attr_remap_pkg;

    localparam int unsigned TYPE_W      = 2;
    localparam int unsigned TYPE_LSB    = 0;
    localparam int unsigned DEV_S0_BIT  = 16;
    localparam int unsigned DEV_S1_BIT  = 17;
    localparam int unsigned NRM_S0_BIT  = 18;
    localparam int unsigned NRM_S1_BIT  = 19;
    localparam int unsigned RSV_LSB     = 20;
    localparam int unsigned RSV_MSB     = 23;
    localparam int unsigned OUTER_LSB   = 24;
    localparam int unsigned N_BANKS     = 2;
    localparam int unsigned BANK_NS     = 0;
    localparam int unsigned BANK_S      = 1;

    typedef enum logic [1:0] {
        MT_DEV_STRICT = 2'b00,
        MT_DEV_OTHER  = 2'b01,
        MT_NORMAL     = 2'b10,
        MT_UNDEF      = 2'b11
    } mem_type_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'b00,
        SH_INNER = 2'b01,
        SH_OUTER = 2'b10
    } share_e;

    localparam logic [1:0] EL_USER = 2'd0;

    // Bits that hold state; every other bit reads as zero.
    function automatic logic [31:0] keep_mask(input int unsigned n_idx);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i >= TYPE_LSB && i < TYPE_LSB + TYPE_W * n_idx) m[i] = 1'b1;
            if (i >= DEV_S0_BIT && i <= NRM_S1_BIT)               m[i] = 1'b1;
            if (i >= OUTER_LSB && i < OUTER_LSB + n_idx)          m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/attr_access_ctl.sv
module attr_access_ctl
    import attr_remap_pkg::*;
#(
    parameter int unsigned BANKS = N_BANKS
) (
    input  logic             req,
    input  logic             wr,
    input  logic [1:0]       el,
    input  logic             secure,
    input  logic             long_fmt,
    input  logic             sec_wr_lock,
    output logic [BANKS-1:0] wr_en,
    output logic             rd_en,
    output logic             deny
);

    logic privileged;
    logic fmt_ok;
    logic locked;

    always_comb begin
        privileged = (el != EL_USER);
        fmt_ok     = !long_fmt;
        locked     = wr && secure && sec_wr_lock;
        wr_en      = '0;
        rd_en      = 1'b0;
        deny       = 1'b0;
        if (req) begin
            if (!privileged || !fmt_ok || locked) begin
                deny = 1'b1;
            end else if (wr) begin
                wr_en[secure ? BANK_S : BANK_NS] = 1'b1;
            end else begin
                rd_en = 1'b1;
            end
        end
    end

endmodule

// File: rtl/attr_reg_bank.sv
module attr_reg_bank
    import attr_remap_pkg::*;
#(
    parameter int unsigned REG_W = 32,
    parameter int unsigned N_IDX = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] value
);

    localparam logic [31:0] KEEP = keep_mask(N_IDX);

    typedef struct packed {
        logic [REG_W-1:0] word;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = wdata & KEEP[REG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.word;

endmodule

// File: rtl/attr_lookup.sv
module attr_lookup
    import attr_remap_pkg::*;
#(
    parameter int unsigned REG_W = 32,
    parameter int unsigned IDX_W = 3
) (
    input  logic [REG_W-1:0] cfg,
    input  logic [IDX_W-1:0] idx,
    input  logic             share_in,
    output logic [1:0]       mtype,
    output logic [1:0]       share,
    output logic             err
);

    logic [TYPE_W-1:0] code;
    logic              nrm_shareable;
    logic              pick_inner;
    logic              unused_dev;

    assign unused_dev = ^{cfg[DEV_S1_BIT], cfg[DEV_S0_BIT], cfg[RSV_MSB:RSV_LSB]};

    always_comb begin
        code          = cfg[TYPE_LSB + TYPE_W * int'(idx) +: TYPE_W];
        nrm_shareable = share_in ? cfg[NRM_S1_BIT] : cfg[NRM_S0_BIT];
        pick_inner    = cfg[OUTER_LSB + int'(idx)];
        err           = 1'b0;
        mtype         = MT_DEV_STRICT;
        share         = SH_OUTER;
        unique case (mem_type_e'(code))
            MT_DEV_STRICT, MT_DEV_OTHER: begin
                mtype = code;
                share = SH_OUTER;
            end
            MT_NORMAL: begin
                mtype = MT_NORMAL;
                if (!nrm_shareable) share = SH_NONE;
                else if (pick_inner) share = SH_INNER;
                else share = SH_OUTER;
            end
            MT_UNDEF: begin
                err   = 1'b1;
                mtype = MT_DEV_STRICT;
                share = SH_OUTER;
            end
            default: begin
                err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/attr_remap_bank.sv
module attr_remap_bank
    import attr_remap_pkg::*;
#(
    parameter int unsigned REG_W = 32,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_req,
    input  logic             reg_wr,
    input  logic [1:0]       reg_el,
    input  logic             reg_secure,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             reg_fault,
    input  logic             long_fmt,
    input  logic             sec_wr_lock,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic             lk_share_in,
    input  logic             lk_secure,
    output logic [1:0]       lk_type,
    output logic [1:0]       lk_share,
    output logic             lk_err
);

    localparam int unsigned N_IDX = 1 << IDX_W;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
        logic             fault;
    } port_state_t;

    logic [N_BANKS-1:0]            wr_en;
    logic                          rd_en;
    logic                          deny;
    logic [N_BANKS-1:0][REG_W-1:0] bank_q;
    port_state_t                   ps_d, ps_q;

    attr_access_ctl #(.BANKS(N_BANKS)) u_ctl (
        .req         (reg_req),
        .wr          (reg_wr),
        .el          (reg_el),
        .secure      (reg_secure),
        .long_fmt    (long_fmt),
        .sec_wr_lock (sec_wr_lock),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .deny        (deny)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        attr_reg_bank #(.REG_W(REG_W), .N_IDX(N_IDX)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en[b]),
            .wdata (reg_wdata),
            .value (bank_q[b])
        );
    end

    always_comb begin
        ps_d       = '0;
        ps_d.fault = deny;
        if (rd_en) begin
            ps_d.rdata = bank_q[reg_secure ? BANK_S : BANK_NS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign reg_rdata = ps_q.rdata;
    assign reg_fault = ps_q.fault;

    attr_lookup #(.REG_W(REG_W), .IDX_W(IDX_W)) u_lookup (
        .cfg      (bank_q[lk_secure ? BANK_S : BANK_NS]),
        .idx      (lk_idx),
        .share_in (lk_share_in),
        .mtype    (lk_type),
        .share    (lk_share),
        .err      (lk_err)
    );

endmodule

// File: rtl/attr_remap_checker.sv
module attr_remap_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_req,
    input logic        reg_wr,
    input logic [1:0]  reg_el,
    input logic        reg_secure,
    input logic [31:0] reg_rdata,
    input logic        reg_fault,
    input logic        long_fmt,
    input logic        sec_wr_lock,
    input logic [1:0]  lk_type,
    input logic [1:0]  lk_share,
    input logic        lk_err
);

    AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (reg_rdata == 32'd0 && !reg_fault)); // R1
    AST_USER_DENIED: assert property (@(posedge clk) disable iff (rst) (reg_req && reg_el == 2'd0) |=> (reg_fault && reg_rdata == 32'd0)); // R2
    AST_LONG_DENIED: assert property (@(posedge clk) disable iff (rst) (reg_req && long_fmt) |=> (reg_fault && reg_rdata == 32'd0)); // R3
    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (rst) (reg_req && reg_wr && reg_secure && sec_wr_lock) |=> reg_fault); // R5
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst) reg_rdata[23:20] == 4'd0); // R6
    AST_TYPE_DEFINED: assert property (@(posedge clk) disable iff (rst) lk_type != 2'b11); // R7
    AST_NONE_ONLY_NORMAL: assert property (@(posedge clk) disable iff (rst) (lk_share == 2'b00) |-> (lk_type == 2'b10)); // R8
    AST_DEVICE_OUTER: assert property (@(posedge clk) disable iff (rst) (lk_type != 2'b10) |-> (lk_share == 2'b10)); // R10
    AST_UNDEF_FORCED: assert property (@(posedge clk) disable iff (rst) lk_err |-> (lk_type == 2'b00 && lk_share == 2'b10)); // R11
    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst) reg_fault |-> $past(reg_req)); // R12

endmodule

bind attr_remap_bank attr_remap_checker u_chk (.*);

// File: tb/attr_remap_bank_bench.sv
module attr_remap_bank_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_req, reg_wr, reg_secure, long_fmt, sec_wr_lock;
    logic [1:0]  reg_el;
    logic [31:0] reg_wdata, reg_rdata;
    logic        reg_fault;
    logic [2:0]  lk_idx;
    logic        lk_share_in, lk_secure;
    logic [1:0]  lk_type, lk_share;
    logic        lk_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] mdl [2];

    always #10 clk = ~clk;

    attr_remap_bank u_attr_remap_bank (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] el, input logic sec,
                          input logic [31:0] data, output logic flt, output logic [31:0] rd);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = wr; reg_el = el; reg_secure = sec; reg_wdata = data;
        @(negedge clk);
        reg_req = 1'b0; reg_wr = 1'b0;
        flt = reg_fault; rd = reg_rdata;
    endtask

    task automatic readback(input logic sec, input string req);
        logic f; logic [31:0] r;
        access(1'b0, 2'd1, sec, 32'd0, f, r);
        chk(!f && r == mdl[sec], req, r, mdl[sec]);
    endtask

    task automatic sweep();
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 8; n++) begin
                for (int sh = 0; sh < 2; sh++) begin
                    logic [31:0] v; logic [1:0] t, et, es; logic ee, sb;
                    lk_secure = s[0]; lk_idx = n[2:0]; lk_share_in = sh[0];
                    #2;
                    v = mdl[s]; t = v[2*n +: 2];
                    ee = 1'b0; et = t; es = 2'b10;
                    if (t == 2'b11) begin ee = 1'b1; et = 2'b00; end
                    else if (t == 2'b10) begin
                        sb = sh[0] ? v[19] : v[18];
                        es = !sb ? 2'b00 : (v[24+n] ? 2'b01 : 2'b10);
                    end
                    chk(lk_type == et, "R7 type", {30'd0, lk_type}, {30'd0, et});
                    if (ee) chk(lk_err && lk_share == es, "R11 undefined code", {29'd0, lk_err, lk_share}, {29'd0, ee, es});
                    else if (t != 2'b10) chk(!lk_err && lk_share == es, "R10 device share", {29'd0, lk_err, lk_share}, {29'd0, ee, es});
                    else if (es == 2'b00) chk(!lk_err && lk_share == es, "R8 normal share", {29'd0, lk_err, lk_share}, {29'd0, ee, es});
                    else chk(!lk_err && lk_share == es, "R9 inner/outer", {29'd0, lk_err, lk_share}, {29'd0, ee, es});
                end
            end
        end
    endtask

    initial begin
        logic f; logic [31:0] r; logic [31:0] pat; logic [31:0] lfsr;
        rst = 1'b1; reg_req = 0; reg_wr = 0; reg_el = 0; reg_secure = 0; reg_wdata = 0;
        long_fmt = 0; sec_wr_lock = 0; lk_idx = 0; lk_share_in = 0; lk_secure = 0;
        mdl[0] = 0; mdl[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(reg_rdata == 0 && !reg_fault, "R1 reset outputs", {reg_fault, reg_rdata[30:0]}, 32'd0);
        readback(1'b0, "R1 NS copy zero");
        readback(1'b1, "R1 S copy zero");
        sweep();

        lfsr = 32'hACE1_2468;
        for (int p = 0; p < 10; p++) begin
            case (p)
                0: pat = 32'hFFFF_FFFF;
                1: pat = 32'hAAAA_AAAA;
                2: pat = 32'h00F0_5555;
                3: pat = 32'h5A08_E4B1;
                4: pat = 32'hC3FC_9A6E;
                default: begin
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    pat = lfsr ^ (lfsr << 7);
                end
            endcase
            for (int s = 0; s < 2; s++) begin
                logic [31:0] other;
                other = mdl[1-s];
                access(1'b1, 2'(1 + (p + s) % 3), s[0], pat ^ {32{s[0]}}, f, r);
                chk(!f, "R4 granted write", {31'd0, f}, 32'd0);
                mdl[s] = (pat ^ {32{s[0]}}) & 32'hFF0F_FFFF;
                readback(s[0], "R6 R4 readback");
                readback(~s[0], "R4 other copy kept");
                chk(mdl[1-s] == other, "R4 model", mdl[1-s], other);
            end
            sweep();
        end

        // R10: device bits and outer bits do not move device results
        access(1'b1, 2'd2, 1'b0, 32'h0003_5555, f, r); mdl[0] = 32'h0003_5555; sweep();
        access(1'b1, 2'd2, 1'b0, 32'hFF0C_5555, f, r); mdl[0] = 32'hFF0C_5555; sweep();

        // R2: unprivileged
        access(1'b1, 2'd0, 1'b0, 32'h1234_5678, f, r);
        chk(f, "R2 write fault", {31'd0, f}, 32'd1);
        readback(1'b0, "R2 NS unchanged");
        access(1'b0, 2'd0, 1'b1, 32'd0, f, r);
        chk(f && r == 0, "R2 read refused", r, 32'd0);
        // R12: one-cycle pulse
        @(negedge clk);
        chk(!reg_fault, "R12 pulse ends", {31'd0, reg_fault}, 32'd0);

        // R3: long format
        long_fmt = 1'b1;
        access(1'b1, 2'd3, 1'b1, 32'h0F0F_0F0F, f, r);
        chk(f, "R3 write fault", {31'd0, f}, 32'd1);
        access(1'b0, 2'd3, 1'b1, 32'd0, f, r);
        chk(f && r == 0, "R3 read refused", r, 32'd0);
        long_fmt = 1'b0;
        readback(1'b1, "R3 S unchanged");

        // R5: secure write lock
        sec_wr_lock = 1'b1;
        access(1'b1, 2'd3, 1'b1, 32'h9999_9999, f, r);
        chk(f, "R5 locked write fault", {31'd0, f}, 32'd1);
        readback(1'b1, "R5 S unchanged, read allowed");
        access(1'b1, 2'd1, 1'b0, 32'h8642_AAAA, f, r);
        chk(!f, "R5 NS write allowed", {31'd0, f}, 32'd0);
        mdl[0] = 32'h8642_AAAA & 32'hFF0F_FFFF;
        readback(1'b0, "R5 NS written");
        sec_wr_lock = 1'b0;
        sweep();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule